// File: doc/BRIEF.md
# Driver Fault and Step-Loss Monitor

This block sits beside the current regulator of a two-coil H-bridge motor driver and turns its raw protection signals into latched status flags. The inputs are a supply-low comparator, two temperature comparators (warning and shutdown), eight overcurrent comparators (one per bridge transistor), a per-coil indicator that the PWM duty is pinned at 100%, the current translator position, strobes for step requests and position writes, and read strobes for three status groups. It owns the debounce timers, the read-to-clear rules, the motor-enable bit and the per-bridge drive gating, and it drives an active-low error line meant for an open-drain pad.

Every fault has its own clearing and re-enable rule. A flag that reflects a live condition clears on its group's read strobe only once the condition has gone, and the set condition always wins over a clear in the same cycle. A step-loss flag records that a step or position write was requested while a fault was blocking motion. The millisecond timeouts are derived from the system clock through a prescaler of `CLK_PER_MS` cycles that restarts with each timer, so a timeout of N ms expires after exactly N x `CLK_PER_MS` cycles of continuous condition.

All inputs are taken to be synchronous to `clk`; the comparators are synchronised outside the block.

Top module: `drv_fault_monitor`

## Requirements
- R1: With `uv_cmp_i` held high, `uv_o` rises on the clock edge after N x `CLK_PER_MS` edges of continuous high input, where N is 0, 5, 10 or 30 ms for `uv_code_i` 0, 1, 2 or 3; any low cycle restarts the count. While `uv_o` is 1, `err_n_o` is 0. `uv_o` clears on `rd_supply_i` only when `uv_cmp_i` is low.
- R2: `uvw_o` is set one edge after `uv_cmp_i` is high, and clears on `rd_supply_i` only when `uv_cmp_i` is low.
- R3: While `uv_o` is 1 both bits of `bridge_en_o` are 0; `brake_o` equals `uv_brake_i` (1 = bottom switches short the coils, 0 = high impedance); otherwise `brake_o` is 0.
- R4: Coil X (bit 0) or Y (bit 1) gets `open_o` set after M x `CLK_PER_MS` edges of continuous `duty_full_i` high, M being 5, 25, 50 or 200 ms for `open_code_i` 0 to 3. Coil X is not timed at `msp_i` 16 or 48, coil Y not at `msp_i` 0 or 32. Open flags clear on `rd_fault_i` when the coil's duty indicator is no longer timed.
- R5: With `open_ignore_i` = 1 open flags leave the bridges and enable untouched; else with `open_hiz_i` = 1 any open flag turns off both bridges and clears `motor_en_o`; else only the affected coil's `bridge_en_o` bit goes to 0.
- R6: `short_o[i]` latches `oc_cmp_i[i]` (bits 0..3 coil X, 4..7 coil Y; within a coil: P-top, P-bottom, N-top, N-bottom) and clears on `rd_fault_i` unless the comparator is still high; while any short flag is set `motor_en_o` is forced to 0 from the next edge.
- R7: `eldef_o` is the OR of the eight short flags and the two open flags.
- R8: `sl_o` sets when `step_i` or `pos_wr_i` is high while `uv_o`, `tsd_o` or `eldef_o` is 1; it clears on `rd_misc_i`.
- R9: `tw_o` latches `tw_cmp_i` and pulls `err_n_o` low without touching `motor_en_o`; `tsd_o` latches `tsd_cmp_i` and clears `motor_en_o`; both clear on `rd_misc_i` only when `tw_cmp_i` and `tsd_cmp_i` are low.
- R10: After reset `motor_en_o` and all flags are 0. A write of 1 (`en_wr_i` with `en_wdata_i` = 1) sets `motor_en_o` only when `uv_o`, `tw_o` and `tsd_o` are 0, else it is ignored; a write of 0 always clears it.
- R11: `err_n_o` is 0 exactly when `uv_o`, `tw_o`, `tsd_o`, `eldef_o` or `stall_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_cmp_i | input | 1 | Supply below threshold |
| tw_cmp_i | input | 1 | Temperature above warning level |
| tsd_cmp_i | input | 1 | Temperature above shutdown level |
| oc_cmp_i | input | 8 | Per-transistor overcurrent comparators |
| duty_full_i | input | 2 | Coil PWM pinned at 100% (bit 0 X, bit 1 Y) |
| msp_i | input | 6 | Current translator position |
| step_i | input | 1 | Step trigger strobe |
| pos_wr_i | input | 1 | Position write strobe |
| stall_i | input | 1 | Stall condition from the motion detector |
| uv_code_i | input | 2 | Supply-low debounce selection |
| open_code_i | input | 2 | Open-coil timeout selection |
| uv_brake_i | input | 1 | Supply-low reaction: 1 brake, 0 high impedance |
| open_hiz_i | input | 1 | Open coil disables both bridges |
| open_ignore_i | input | 1 | Open coil leaves bridges active |
| en_wr_i | input | 1 | Write strobe for the enable bit |
| en_wdata_i | input | 1 | Value written to the enable bit |
| rd_supply_i | input | 1 | Read strobe of supply status group |
| rd_fault_i | input | 1 | Read strobe of short/open status group |
| rd_misc_i | input | 1 | Read strobe of thermal and step-loss group |
| motor_en_o | output | 1 | Motor enable bit |
| bridge_en_o | output | 2 | Per-bridge drive enable (bit 0 X, bit 1 Y) |
| brake_o | output | 1 | Both bottom switches on |
| uvw_o | output | 1 | Supply-low warning flag |
| uv_o | output | 1 | Debounced supply-low fault flag |
| tw_o | output | 1 | Thermal warning flag |
| tsd_o | output | 1 | Thermal shutdown flag |
| short_o | output | 8 | Per-transistor short flags |
| open_o | output | 2 | Per-coil open flags |
| eldef_o | output | 1 | Electrical defect summary |
| sl_o | output | 1 | Step-loss flag |
| err_n_o | output | 1 | Error line, 0 pulls the pad low |

## Verification
A timer that miscounts shows up as `uv_o` or `open_o` rising one or more edges away from N x `CLK_PER_MS` + 1 after the condition starts, so the boundary edge itself is sampled on both sides. A flag whose hold rule is wrong clears on the first read strobe issued while its comparator is still high, visible on the very next cycle. An enable register with a wrong gate shows as `motor_en_o` rising after a rejected write, or staying high one edge after a short or shutdown flag appears, and the gating of `bridge_en_o` and `brake_o` follows in the same cycle as the flag.

// File: rtl/drv_fault_pkg.sv
// Package: shared widths and the timeout decode tables of the fault monitor.
// Assumes timeouts are whole milliseconds not exceeding 255.
package drv_fault_pkg;
    localparam int MS_W = 8;

    // Supply-low debounce in ms for a 2-bit code.
    function automatic logic [MS_W-1:0] uv_limit_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd0;
            2'd1:    return 8'd5;
            2'd2:    return 8'd10;
            default: return 8'd30;
        endcase
    endfunction

    // Open-coil timeout in ms for a 2-bit code.
    function automatic logic [MS_W-1:0] open_limit_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd5;
            2'd1:    return 8'd25;
            2'd2:    return 8'd50;
            default: return 8'd200;
        endcase
    endfunction
endpackage

// File: rtl/drv_ms_timer.sv
// Module: restartable millisecond timer. Counts clock cycles up to CLK_PER_MS,
// then whole milliseconds (saturating). Any cycle with run_i low restarts it.
// expired_o is high while running and the elapsed ms reach limit_i.
module drv_ms_timer #(
    parameter int CLK_PER_MS = 10000,
    parameter int MS_W       = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [MS_W-1:0] limit_i,
    output logic            expired_o
);
    localparam int CYC_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(CLK_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_MAX   = '1;

    logic [CYC_W-1:0] cyc_q;
    logic [MS_W-1:0]  ms_q;

    // Prescaler and millisecond counter, cleared whenever the condition drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cyc_q <= '0;
            ms_q  <= '0;
        end else if (cyc_q == CYC_LAST) begin
            cyc_q <= '0;
            if (ms_q != MS_MAX) ms_q <= ms_q + 1'b1;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Expiry compare against the selected limit.
    always_comb expired_o = run_i && (ms_q >= limit_i);

    // R1/R4: a dropped condition leaves the timer at zero on the next edge.
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (ms_q == '0) && (cyc_q == '0));
endmodule

// File: rtl/drv_sticky_flag.sv
// Module: one status flag. Set wins; the read strobe clears it only while
// the hold condition (the fault still present) is low.
module drv_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic hold_i,
    output logic q_o
);
    // Latch on set, release on read once the condition has gone.
    always_ff @(posedge clk) begin
        if (!rst_n)                q_o <= 1'b0;
        else if (set_i)            q_o <= 1'b1;
        else if (rd_i && !hold_i)  q_o <= 1'b0;
    end

    // R2/R6/R9: a flag with its condition still present survives a read.
    a_r6_hold_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        q_o && hold_i |=> q_o);
endmodule

// File: rtl/drv_fault_monitor.sv
// Module: fault and step-loss monitor of a two-coil H-bridge driver.
// Turns comparator inputs into latched flags, gates the motor enable and
// the per-bridge drive, and produces the active-low error line.
// Assumes all inputs are synchronous to clk; CLK_PER_MS cycles form 1 ms.
module drv_fault_monitor
    import drv_fault_pkg::*;
#(
    parameter int CLK_PER_MS = 10000,
    parameter int N_COIL     = 2,
    parameter int N_SW       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   uv_cmp_i,
    input  logic                   tw_cmp_i,
    input  logic                   tsd_cmp_i,
    input  logic [N_COIL*N_SW-1:0] oc_cmp_i,
    input  logic [N_COIL-1:0]      duty_full_i,
    input  logic [5:0]             msp_i,
    input  logic                   step_i,
    input  logic                   pos_wr_i,
    input  logic                   stall_i,
    input  logic [1:0]             uv_code_i,
    input  logic [1:0]             open_code_i,
    input  logic                   uv_brake_i,
    input  logic                   open_hiz_i,
    input  logic                   open_ignore_i,
    input  logic                   en_wr_i,
    input  logic                   en_wdata_i,
    input  logic                   rd_supply_i,
    input  logic                   rd_fault_i,
    input  logic                   rd_misc_i,
    output logic                   motor_en_o,
    output logic [N_COIL-1:0]      bridge_en_o,
    output logic                   brake_o,
    output logic                   uvw_o,
    output logic                   uv_o,
    output logic                   tw_o,
    output logic                   tsd_o,
    output logic [N_COIL*N_SW-1:0] short_o,
    output logic [N_COIL-1:0]      open_o,
    output logic                   eldef_o,
    output logic                   sl_o,
    output logic                   err_n_o
);
    localparam int N_SHORT = N_COIL * N_SW;

    logic              uv_expired;
    logic [N_COIL-1:0] coil_live;
    logic [N_COIL-1:0] open_run;
    logic [N_COIL-1:0] open_expired;
    logic [N_COIL-1:0] open_off;
    logic              open_kill;
    logic              en_kill;
    logic              en_ok;
    logic              step_req;

    // ---------------- supply monitoring ----------------
    drv_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) i_uv_timer (
        .clk(clk), .rst_n(rst_n), .run_i(uv_cmp_i),
        .limit_i(uv_limit_ms(uv_code_i)), .expired_o(uv_expired)
    );

    drv_sticky_flag i_uvw_flag (
        .clk(clk), .rst_n(rst_n), .set_i(uv_cmp_i), .rd_i(rd_supply_i),
        .hold_i(uv_cmp_i), .q_o(uvw_o)
    );

    drv_sticky_flag i_uv_flag (
        .clk(clk), .rst_n(rst_n), .set_i(uv_expired), .rd_i(rd_supply_i),
        .hold_i(uv_cmp_i), .q_o(uv_o)
    );

    // ---------------- thermal monitoring ----------------
    drv_sticky_flag i_tw_flag (
        .clk(clk), .rst_n(rst_n), .set_i(tw_cmp_i), .rd_i(rd_misc_i),
        .hold_i(tw_cmp_i || tsd_cmp_i), .q_o(tw_o)
    );

    drv_sticky_flag i_tsd_flag (
        .clk(clk), .rst_n(rst_n), .set_i(tsd_cmp_i), .rd_i(rd_misc_i),
        .hold_i(tw_cmp_i || tsd_cmp_i), .q_o(tsd_o)
    );

    // ---------------- short flags, one per transistor ----------------
    for (genvar s = 0; s < N_SHORT; s++) begin : g_short
        drv_sticky_flag i_short_flag (
            .clk(clk), .rst_n(rst_n), .set_i(oc_cmp_i[s]), .rd_i(rd_fault_i),
            .hold_i(oc_cmp_i[s]), .q_o(short_o[s])
        );
    end

    // ---------------- open-coil detection per coil ----------------
    // Coils carry no current at quarter-turn positions: X at 16/48, Y at 0/32.
    always_comb begin
        coil_live[0] = !(msp_i == 6'd16 || msp_i == 6'd48);
        coil_live[1] = !(msp_i == 6'd0  || msp_i == 6'd32);
    end

    for (genvar c = 0; c < N_COIL; c++) begin : g_open
        assign open_run[c] = duty_full_i[c] && coil_live[c];

        drv_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS_W(MS_W)) i_open_timer (
            .clk(clk), .rst_n(rst_n), .run_i(open_run[c]),
            .limit_i(open_limit_ms(open_code_i)), .expired_o(open_expired[c])
        );

        drv_sticky_flag i_open_flag (
            .clk(clk), .rst_n(rst_n), .set_i(open_expired[c]), .rd_i(rd_fault_i),
            .hold_i(open_run[c]), .q_o(open_o[c])
        );

        // R4: an open flag can only appear while that coil was being timed.
        a_r4_open_needs_duty: assert property (@(posedge clk) disable iff (!rst_n)
            !open_o[c] && !open_run[c] |=> !open_o[c]);
    end

    // Summary and open-coil reaction selection.
    always_comb begin
        eldef_o = (|short_o) || (|open_o);
        if (open_ignore_i)   open_off = '0;
        else if (open_hiz_i) open_off = {N_COIL{|open_o}};
        else                 open_off = open_o;
        open_kill = open_hiz_i && !open_ignore_i && (|open_o);
    end

    // ---------------- step loss ----------------
    always_comb step_req = step_i || pos_wr_i;

    drv_sticky_flag i_sl_flag (
        .clk(clk), .rst_n(rst_n), .set_i(step_req && (uv_o || tsd_o || eldef_o)),
        .rd_i(rd_misc_i), .hold_i(1'b0), .q_o(sl_o)
    );

    // ---------------- motor enable ----------------
    always_comb begin
        en_kill = tsd_o || (|short_o) || open_kill;
        en_ok   = !uv_o && !tw_o && !tsd_o;
    end

    // Enable register: faults dominate, a write of 0 always lands,
    // a write of 1 only lands while the supply and thermal flags are clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                               motor_en_o <= 1'b0;
        else if (en_kill)                         motor_en_o <= 1'b0;
        else if (en_wr_i && !en_wdata_i)          motor_en_o <= 1'b0;
        else if (en_wr_i && en_wdata_i && en_ok)  motor_en_o <= 1'b1;
    end

    // Bridge drive gating and brake selection.
    always_comb begin
        brake_o     = uv_o && uv_brake_i;
        bridge_en_o = uv_o ? '0 : ({N_COIL{motor_en_o}} & ~open_off);
        err_n_o     = !(uv_o || tw_o || tsd_o || eldef_o || stall_i);
    end

    // R10: the enable bit only rises after an accepted write with clean flags.
    a_r10_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !motor_en_o ##1 motor_en_o |-> $past(en_wr_i && en_wdata_i && !uv_o && !tw_o && !tsd_o));

    // R6: a latched short forbids the enable on the following edge.
    a_r6_short_kills_en: assert property (@(posedge clk) disable iff (!rst_n)
        (|short_o) |=> !motor_en_o);

    // R9: shutdown stays latched unless read with both comparators low.
    a_r9_tsd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_o && !(rd_misc_i && !tw_cmp_i && !tsd_cmp_i) |=> tsd_o);

    // R8: a step request under a blocking fault is recorded.
    a_r8_step_loss: assert property (@(posedge clk) disable iff (!rst_n)
        step_req && (uv_o || tsd_o || eldef_o) |=> sl_o);

    // R1: once debounced, the supply-low flag persists while the supply is low.
    a_r1_uv_persist: assert property (@(posedge clk) disable iff (!rst_n)
        uv_o && uv_cmp_i |=> uv_o);
endmodule

// File: tb/test_drv_fault_monitor.sv
// Bench: directed corner cases plus seeded random short-flag traffic,
// checked against expectations computed in the bench.
module test_drv_fault_monitor;
    localparam int C = 4;   // cycles per ms in the bench

    logic clk = 1'b0;
    logic rst_n;
    logic uv_cmp, tw_cmp, tsd_cmp;
    logic [7:0] oc_cmp;
    logic [1:0] duty_full;
    logic [5:0] msp;
    logic step, pos_wr, stall;
    logic [1:0] uv_code, open_code;
    logic uv_brake, open_hiz, open_ignore;
    logic en_wr, en_wdata, rd_supply, rd_fault, rd_misc;
    logic motor_en, brake, uvw, uv, tw, tsd, eldef, sl, err_n;
    logic [1:0] bridge_en, open_f;
    logic [7:0] short_f;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    drv_fault_monitor #(.CLK_PER_MS(C)) i_drv_fault_monitor (
        .clk(clk), .rst_n(rst_n), .uv_cmp_i(uv_cmp), .tw_cmp_i(tw_cmp),
        .tsd_cmp_i(tsd_cmp), .oc_cmp_i(oc_cmp), .duty_full_i(duty_full),
        .msp_i(msp), .step_i(step), .pos_wr_i(pos_wr), .stall_i(stall),
        .uv_code_i(uv_code), .open_code_i(open_code), .uv_brake_i(uv_brake),
        .open_hiz_i(open_hiz), .open_ignore_i(open_ignore), .en_wr_i(en_wr),
        .en_wdata_i(en_wdata), .rd_supply_i(rd_supply), .rd_fault_i(rd_fault),
        .rd_misc_i(rd_misc), .motor_en_o(motor_en), .bridge_en_o(bridge_en),
        .brake_o(brake), .uvw_o(uvw), .uv_o(uv), .tw_o(tw), .tsd_o(tsd),
        .short_o(short_f), .open_o(open_f), .eldef_o(eldef), .sl_o(sl),
        .err_n_o(err_n)
    );

    function automatic int uv_ms(input logic [1:0] code);
        case (code) 2'd0: return 0; 2'd1: return 5; 2'd2: return 10; default: return 30; endcase
    endfunction

    function automatic int open_ms(input logic [1:0] code);
        case (code) 2'd0: return 5; 2'd1: return 25; 2'd2: return 50; default: return 200; endcase
    endfunction

    function automatic logic exp_err_n(input logic f_uv, f_tw, f_tsd, f_el, f_st);
        return !(f_uv || f_tw || f_tsd || f_el || f_st);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rd(input int which);
        if (which == 0) rd_supply = 1'b1;
        if (which == 1) rd_fault  = 1'b1;
        if (which == 2) rd_misc   = 1'b1;
        tick(1);
        rd_supply = 1'b0; rd_fault = 1'b0; rd_misc = 1'b0;
    endtask

    task automatic write_en(input logic v);
        en_wr = 1'b1; en_wdata = v;
        tick(1);
        en_wr = 1'b0; en_wdata = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 8);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] model;
        logic [7:0] prev_model;
        int n;
        rst_n = 1'b0; uv_cmp = 0; tw_cmp = 0; tsd_cmp = 0; oc_cmp = '0;
        duty_full = '0; msp = 6'd8; step = 0; pos_wr = 0; stall = 0;
        uv_code = 2'd1; open_code = 2'd0; uv_brake = 0; open_hiz = 0;
        open_ignore = 0; en_wr = 0; en_wdata = 0; rd_supply = 0; rd_fault = 0; rd_misc = 0;
        void'($urandom(32'h5eed));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R10: reset state
        check("R10 reset enable", motor_en, 0);
        check("R10 reset flags", {uvw, uv, tw, tsd, short_f, open_f, sl}, 0);
        check("R11 reset err_n", err_n, 1);
        write_en(1'b1);
        check("R10 enable write", motor_en, 1);
        check("R10 bridges on", bridge_en, 2'b11);

        // R9: thermal warning keeps enable, blocks re-enable
        tw_cmp = 1'b1; tick(1);
        check("R9 tw flag", tw, 1);
        check("R9 tw keeps enable", motor_en, 1);
        check("R11 err on tw", err_n, exp_err_n(0, 1, 0, 0, 0));
        write_en(1'b0);
        check("R10 write 0", motor_en, 0);
        write_en(1'b1);
        check("R10 write 1 rejected under tw", motor_en, 0);
        pulse_rd(2);
        check("R9 tw held while hot", tw, 1);
        tw_cmp = 1'b0; pulse_rd(2);
        check("R9 tw clears on read", tw, 0);
        write_en(1'b1);
        check("R10 re-enable", motor_en, 1);

        // R9: shutdown
        tsd_cmp = 1'b1; tw_cmp = 1'b1; tick(1); tsd_cmp = 1'b0; tick(1);
        check("R9 tsd flag", tsd, 1);
        check("R9 tsd clears enable", motor_en, 0);
        step = 1'b1; tick(1); step = 1'b0; tick(1);
        check("R8 step under tsd", sl, 1);
        pulse_rd(2);
        check("R9 tsd held above warning", tsd, 1);
        check("R8 sl clears on read", sl, 0);
        tw_cmp = 1'b0; pulse_rd(2);
        check("R9 tsd clears", tsd, 0);
        write_en(1'b1);

        // R1/R2/R3: debounced supply-low, code 1 = 5 ms
        uv_code = 2'd1; uv_cmp = 1'b1; tick(1);
        check("R2 uvw immediate", uvw, 1);
        check("R1 uv not yet", uv, 0);
        tick(uv_ms(2'd1) * C - 1);
        check("R1 uv boundary before", uv, 0);
        tick(1);
        check("R1 uv boundary after", uv, 1);
        check("R1 err on uv", err_n, exp_err_n(1, 0, 0, 0, 0));
        check("R3 hiz reaction", {bridge_en, brake}, 3'b000);
        uv_brake = 1'b1; tick(1);
        check("R3 brake reaction", {bridge_en, brake}, 3'b001);
        pulse_rd(0);
        check("R2 uvw held while low supply", uvw, 1);
        check("R1 uv held while low supply", uv, 1);
        pos_wr = 1'b1; tick(1); pos_wr = 1'b0; tick(1);
        check("R8 pos write under uv", sl, 1);
        uv_cmp = 1'b0; pulse_rd(0);
        check("R2 uvw clears", uvw, 0);
        check("R1 uv clears", uv, 0);
        check("R3 bridges back", {bridge_en, brake}, 3'b110);
        pulse_rd(2);
        uv_brake = 1'b0;

        // R1: restart on a low cycle, then code 0
        uv_code = 2'd2; uv_cmp = 1'b1; tick(20); uv_cmp = 1'b0; tick(1); uv_cmp = 1'b1;
        tick(uv_ms(2'd2) * C - 1);
        check("R1 restart after dropout", uv, 0);
        uv_cmp = 1'b0; pulse_rd(0);
        uv_code = 2'd0; uv_cmp = 1'b1; tick(1);
        check("R1 code 0 immediate", uv, 1);
        uv_cmp = 1'b0; pulse_rd(0);
        check("R1 code 0 cleared", uv, 0);

        // R4/R5: open coil X, default reaction
        open_code = 2'd0; msp = 6'd8; duty_full = 2'b01;
        tick(open_ms(2'd0) * C);
        check("R4 open boundary before", open_f, 2'b00);
        tick(1);
        check("R4 open X after", open_f, 2'b01);
        check("R5 only X off", bridge_en, 2'b10);
        check("R7 eldef from open", eldef, 1);
        check("R11 err on open", err_n, exp_err_n(0, 0, 0, 1, 0));
        duty_full = 2'b00; pulse_rd(1);
        check("R4 open clears", open_f, 0);
        check("R5 bridges restored", bridge_en, 2'b11);

        // R4: exempt positions
        msp = 6'd16; duty_full = 2'b01; tick(open_ms(2'd0) * C + 8);
        check("R4 X exempt at 16", open_f, 0);
        duty_full = 2'b10; tick(open_ms(2'd0) * C + 1);
        check("R4 Y timed at 16", open_f, 2'b10);
        check("R5 only Y off", bridge_en, 2'b01);
        duty_full = 2'b00; pulse_rd(1);
        msp = 6'd32; duty_full = 2'b10; tick(open_ms(2'd0) * C + 8);
        check("R4 Y exempt at 32", open_f, 0);
        duty_full = 2'b00; msp = 6'd8;

        // R4: code 1 = 25 ms boundary
        open_code = 2'd1; duty_full = 2'b10; tick(open_ms(2'd1) * C);
        check("R4 code1 before", open_f, 0);
        tick(1);
        check("R4 code1 after", open_f, 2'b10);
        duty_full = 2'b00; pulse_rd(1); open_code = 2'd0;

        // R5: high-impedance reaction
        open_hiz = 1'b1; duty_full = 2'b01; tick(open_ms(2'd0) * C + 1);
        check("R5 hiz both off", bridge_en, 2'b00);
        tick(1);
        check("R5 hiz clears enable", motor_en, 0);
        duty_full = 2'b00; pulse_rd(1); write_en(1'b1);
        check("R5 re-enable after open", motor_en, 1);

        // R5: ignore overrides
        open_ignore = 1'b1; duty_full = 2'b01; tick(open_ms(2'd0) * C + 2);
        check("R5 ignore flag set", open_f, 2'b01);
        check("R5 ignore bridges", bridge_en, 2'b11);
        check("R5 ignore enable", motor_en, 1);
        duty_full = 2'b00; pulse_rd(1);
        open_ignore = 1'b0; open_hiz = 1'b0;

        // R11: stall alone
        stall = 1'b1; tick(1);
        check("R11 stall err", err_n, exp_err_n(0, 0, 0, 0, 1));
        stall = 1'b0; tick(1);
        check("R11 err released", err_n, 1);

        // R6/R7: seeded random short traffic with a bench model
        model = '0;
        prev_model = '0;
        for (int i = 0; i < 300; i++) begin
            n = $urandom % 10;
            oc_cmp = (n == 0) ? (8'd1 << ($urandom % 8)) : 8'd0;
            rd_fault = (($urandom % 4) == 0);
            tick(1);
            prev_model = model;
            model = oc_cmp | (model & ~{8{rd_fault}});
            check("R6 short flags", short_f, model);
            check("R7 eldef", eldef, |model);
            check("R11 err shorts", err_n, exp_err_n(0, 0, 0, |model, 0));
            if (i > 0 && prev_model != 0) check("R6 enable killed", motor_en, 0);
            if (motor_en == 1'b0 && model == 0 && ($urandom % 3) == 0) begin
                oc_cmp = '0; rd_fault = 1'b0;
                write_en(1'b1);
                check("R6 re-enable after clear", motor_en, 1);
            end
        end
        oc_cmp = 8'h80; rd_fault = 1'b1; tick(1);
        check("R6 held under read", short_f[7], 1);
        oc_cmp = '0; tick(1); pulse_rd(1);
        check("R6 all clear", short_f, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule